// File: doc/BRIEF.md
# Binary Seconds Counter with Stop Gating

This block keeps a free-running binary count of elapsed seconds. A 32.768 kHz time base reaches it as a single-cycle strobe in the system clock domain. A prescaler folds a parameterised number of those strobes into one increment of a 32-bit count. A host sets the count one byte at a time through a small register port. A host read first captures all count bytes at once into a shadow copy, so a carry that lands during a multi-byte read cannot mix old and new bytes.

A control register holds a stop bit. While the stop bit is set, both the count and the prescaler phase freeze. The stop bit also decides the oscillator-enable output, but only when the block is told it is running from backup supply. On main supply the oscillator always stays enabled. Calendar conversion, the oscillator itself and the supply switching sit outside the block.

Top module: `secs_counter`

## Requirements
- R1: After reset the count, the prescaler phase, the shadow copy and the stop bit are all zero, and the oscillator enable is high.
- R2: While the stop bit is 0, the count rises by exactly one on the clock edge that takes every DIV-th tick strobe. It wraps from all ones to zero.
- R3: While the stop bit is 1, tick strobes change neither the count nor the prescaler phase. Counting resumes from the phase that was held.
- R4: `osc_en_o` is low only when `on_backup_i` is 1 and the stop bit is 1. Otherwise it is high.
- R5: A write to address 0 through 3 replaces that count byte from the next clock edge. Address 0 is the least significant byte and address 3 the most significant. The other bytes keep their values.
- R6: A write to address 3 clears the prescaler phase, so the next increment comes after exactly DIV further strobes.
- R7: When a count-byte write and an increment fall on the same edge, the write wins and that increment is lost.
- R8: The control register sits at address 4. Its bit 7 is the stop bit. Its other bits read as zero.
- R9: A pulse on `snap_i` copies the live count into the shadow. Reads of addresses 0 through 3 return shadow bytes, which do not change until the next pulse.
- R10: Writes to addresses 5 to 7 change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per time-base period |
| on_backup_i | input | 1 | High while running from backup supply |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| snap_i | input | 1 | Capture live count into shadow |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| count_o | output | 32 | Live seconds count |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench builds the block with a prescaler of four. It sends bursts of 1 to 10 strobes, so the carried phase takes every residue, and it compares the count with the running strobe total divided by four. Stopped bursts start from a non-zero phase. Resuming then shows whether the phase was held or lost. Byte writes land on one lane at a time, on the all-ones wrap, and on the same edge as an increment. These separate lane-ordering faults, missing prescaler clears and wrong write priority. Snapshot reads taken before and after a carry show whether the shadow tracks the live count when it should not.

// File: rtl/secs_pkg.sv
package secs_pkg;

   localparam int SECS_BYTE_W  = 8;
   localparam int SECS_DEF_DIV = 32768;

   function automatic bit secs_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/secs_prescaler.sv
module secs_prescaler
   import secs_pkg::*;
#(
   parameter int DIV = SECS_DEF_DIV
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          run_i,
   input  logic          clr_i,
   output logic          wrap_o,
   output logic [$clog2(DIV)-1:0] phase_o
);
   localparam int PW = $clog2(DIV);

   logic [PW-1:0] phase_q;
   logic          last;

   generate
      if (secs_is_pow2(DIV)) begin : g_pow2
         assign last = &phase_q;
      end else begin : g_cmp
         assign last = (phase_q == PW'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         phase_q <= '0;
      end else if (run_i && tick_i) begin
         phase_q <= last ? '0 : phase_q + PW'(1);
      end
   end

   assign wrap_o  = run_i && tick_i && last;
   assign phase_o = phase_q;
endmodule

// File: rtl/secs_count_reg.sv
module secs_count_reg
   import secs_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [SECS_BYTE_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  count_o
);
   localparam int NBYTES = CNT_W / SECS_BYTE_W;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_inc;
   logic             wr_any;

   assign count_inc = count_q + CNT_W'(1);
   assign wr_any    = wr_en_i && (wr_addr_i < ADDR_W'(NBYTES));

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               count_q[g*SECS_BYTE_W +: SECS_BYTE_W] <= '0;
            end else if (wr_any) begin
               if (wr_addr_i == ADDR_W'(g))
                  count_q[g*SECS_BYTE_W +: SECS_BYTE_W] <= wr_data_i;
            end else if (inc_i) begin
               count_q[g*SECS_BYTE_W +: SECS_BYTE_W] <=
                  count_inc[g*SECS_BYTE_W +: SECS_BYTE_W];
            end
         end
      end
   endgenerate

   assign count_o = count_q;
endmodule

// File: rtl/secs_snapshot.sv
module secs_snapshot
   import secs_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int ADDR_W   = 3,
   parameter int STOP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [SECS_BYTE_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]  shadow_o
);
   localparam int NBYTES = CNT_W / SECS_BYTE_W;

   logic [CNT_W-1:0]       shadow_q;
   logic [SECS_BYTE_W-1:0] ctrl_b;

   always_ff @(posedge clk) begin
      if (!rst_n)      shadow_q <= '0;
      else if (snap_i) shadow_q <= count_i;
   end

   always_comb begin
      ctrl_b           = '0;
      ctrl_b[STOP_BIT] = stop_i;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_addr_i == ADDR_W'(i))
            rd_data_o = shadow_q[i*SECS_BYTE_W +: SECS_BYTE_W];
      end
      if (rd_addr_i == ADDR_W'(NBYTES))
         rd_data_o = ctrl_b;
   end

   assign shadow_o = shadow_q;
endmodule

// File: rtl/secs_counter.sv
module secs_counter
   import secs_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int DIV      = SECS_DEF_DIV,
   parameter int ADDR_W   = 3,
   parameter int STOP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              on_backup_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic              snap_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              osc_en_o
);
   localparam int NBYTES    = CNT_W / SECS_BYTE_W;
   localparam int PW        = $clog2(DIV);
   localparam int CTRL_ADDR = NBYTES;
   localparam int TOP_BYTE  = NBYTES - 1;

   generate
      if (CNT_W < SECS_BYTE_W || (CNT_W % SECS_BYTE_W) != 0) begin : g_bad_w
         $error("CNT_W must be a whole number of bytes");
      end
      if (DIV < 2) begin : g_bad_div
         $error("DIV must be at least 2");
      end
      if ((1 << ADDR_W) <= NBYTES) begin : g_bad_addr
         $error("ADDR_W too small to reach the control register");
      end
      if (STOP_BIT < 0 || STOP_BIT >= SECS_BYTE_W) begin : g_bad_stop
         $error("STOP_BIT must lie inside a byte");
      end
   endgenerate

   logic          stop_q;
   logic          inc;
   logic          top_wr;
   logic [PW-1:0] phase_w;
   logic [CNT_W-1:0] shadow_w;

   assign top_wr = wr_en_i && (wr_addr_i == ADDR_W'(TOP_BYTE));

   always_ff @(posedge clk) begin
      if (!rst_n)
         stop_q <= 1'b0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR))
         stop_q <= wr_data_i[STOP_BIT];
   end

   secs_prescaler #(.DIV(DIV)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .run_i   (!stop_q),
      .clr_i   (top_wr),
      .wrap_o  (inc),
      .phase_o (phase_w)
   );

   secs_count_reg #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (inc),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .count_o   (count_o)
   );

   secs_snapshot #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STOP_BIT(STOP_BIT)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .snap_i    (snap_i),
      .count_i   (count_o),
      .stop_i    (stop_q),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o),
      .shadow_o  (shadow_w)
   );

   assign osc_en_o = !(on_backup_i && stop_q);
endmodule

// File: rtl/secs_counter_chk.sv
module secs_counter_chk #(
   parameter int CNT_W  = 32,
   parameter int DIV    = 32768,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              on_backup_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic              snap_i,
   input logic [CNT_W-1:0]  count_o,
   input logic              osc_en_o,
   input logic              stop_q,
   input logic [$clog2(DIV)-1:0] phase_w,
   input logic [CNT_W-1:0]  shadow_w
);
   localparam int NBYTES = CNT_W / 8;

   AST_MAIN_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !on_backup_i |-> osc_en_o); // R4
   AST_BACKUP_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (on_backup_i && stop_q) |-> !osc_en_o); // R4
   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !wr_en_i) |=> ($stable(count_o) && $stable(phase_w))); // R3
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> (count_o == $past(count_o) ||
                    count_o == $past(count_o) + CNT_W'(1))); // R2
   AST_TOP_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADDR_W'(NBYTES - 1)) |=> (phase_w == '0)); // R6
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i |=> $stable(shadow_w)); // R9
   AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i > ADDR_W'(NBYTES)) |=> $stable(stop_q)); // R10
endmodule

bind secs_counter secs_counter_chk #(.CNT_W(CNT_W), .DIV(DIV), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .on_backup_i (on_backup_i),
   .wr_en_i     (wr_en_i),
   .wr_addr_i   (wr_addr_i),
   .snap_i      (snap_i),
   .count_o     (count_o),
   .osc_en_o    (osc_en_o),
   .stop_q      (stop_q),
   .phase_w     (phase_w),
   .shadow_w    (shadow_w)
);

// File: tb/secs_counter_bench.sv
module secs_counter_bench;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        on_backup_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  wr_addr_i = '0;
   logic [7:0]  wr_data_i = '0;
   logic        snap_i = 1'b0;
   logic [2:0]  rd_addr_i = '0;
   logic [7:0]  rd_data_o;
   logic [31:0] count_o;
   logic        osc_en_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   secs_counter #(.CNT_W(32), .DIV(DIV), .ADDR_W(3), .STOP_BIT(7)) u_secs_counter (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .on_backup_i(on_backup_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .snap_i(snap_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .count_o(count_o), .osc_en_o(osc_en_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_addr_i = a;
      #1;
      d = rd_data_o;
   endtask

   task automatic snap();
      @(negedge clk) snap_i = 1'b1;
      @(negedge clk) snap_i = 1'b0;
   endtask

   task automatic rd_shadow(output logic [31:0] v);
      logic [7:0] b;
      for (int i = 0; i < 4; i++) begin
         rd(3'(i), b);
         v[i*8 +: 8] = b;
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  b;
      int          acc;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", count_o, 0);
      chk("R1 osc_en", 32'(osc_en_o), 1);
      rd_shadow(v);
      chk("R1 shadow", v, 0);
      rd(3'd4, b);
      chk("R1 ctrl", 32'(b), 0);

      // R2 sweep of burst lengths, expected = strobes / DIV
      acc = 0;
      for (int k = 1; k <= 10; k++) begin
         ticks(k);
         acc += k;
         chk("R2 sweep", count_o, 32'(acc / DIV));
      end
      // acc = 55, phase = 3, count = 13

      // R3/R8 stop holds count and phase
      wr(3'd4, 8'h80);
      rd(3'd4, b);
      chk("R8 ctrl stop set", 32'(b), 32'h80);
      ticks(9);
      chk("R3 stopped count", count_o, 13);
      chk("R4 main supply", 32'(osc_en_o), 1);
      @(negedge clk) on_backup_i = 1'b1;
      #1 chk("R4 backup stopped", 32'(osc_en_o), 0);
      wr(3'd4, 8'h00);
      chk("R4 backup running", 32'(osc_en_o), 1);
      on_backup_i = 1'b0;
      ticks(1);
      chk("R3 phase held", count_o, 14);

      // R8 only bit 7 stored
      wr(3'd4, 8'hFF);
      rd(3'd4, b);
      chk("R8 ctrl ff", 32'(b), 32'h80);
      wr(3'd4, 8'h7F);
      rd(3'd4, b);
      chk("R8 ctrl 7f", 32'(b), 32'h00);

      // R10 high addresses ignored
      wr(3'd5, 8'h80);
      wr(3'd7, 8'hFF);
      rd(3'd4, b);
      chk("R10 ctrl untouched", 32'(b), 0);
      chk("R10 count untouched", count_o, 14);
      for (int a = 5; a < 8; a++) begin
         rd(3'(a), b);
         chk("R10 read zero", 32'(b), 0);
      end
      ticks(4);
      chk("R10 still counting", count_o, 15);

      // R5 lane placement
      wr(3'd0, 8'h11);
      chk("R5 byte0", count_o, 32'h0000_0011);
      wr(3'd2, 8'hA5);
      chk("R5 byte2", count_o, 32'h00A5_0011);
      wr(3'd3, 8'h3C);
      chk("R5 byte3", count_o, 32'h3CA5_0011);

      // R6 top-byte write clears phase
      ticks(2);
      wr(3'd3, 8'h3C);
      ticks(DIV - 1);
      chk("R6 no early step", count_o, 32'h3CA5_0011);
      ticks(1);
      chk("R6 step after DIV", count_o, 32'h3CA5_0012);

      // R2 wrap from all ones
      for (int a = 0; a < 4; a++) wr(3'(a), 8'hFF);
      chk("R5 all ones", count_o, 32'hFFFF_FFFF);
      ticks(DIV);
      chk("R2 wrap", count_o, 0);

      // R7 write beats increment on the same edge
      ticks(DIV - 1);
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 8'h5A;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      chk("R7 write wins", count_o, 32'h0000_5A00);
      ticks(DIV);
      chk("R7 phase wrapped", count_o, 32'h0000_5A01);

      // R9 snapshot coherence
      snap();
      rd_shadow(v);
      chk("R9 snap", v, 32'h0000_5A01);
      ticks(DIV);
      chk("R9 live moved", count_o, 32'h0000_5A02);
      rd_shadow(v);
      chk("R9 shadow held", v, 32'h0000_5A01);
      snap();
      rd_shadow(v);
      chk("R9 resnap", v, 32'h0000_5A02);

      // R1 reset mid-run
      wr(3'd4, 8'h80);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      chk("R1 count after reset", count_o, 0);
      rd(3'd4, b);
      chk("R1 ctrl after reset", 32'(b), 0);
      rd_shadow(v);
      chk("R1 shadow after reset", v, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule